// File: doc/BRIEF.md
# Section Translation and Domain Permission Checker

This block turns a 32-bit virtual address into a physical address through a single-level directory of 1 MB section descriptors. It then decides whether the access may proceed. A requester presents the address, a write flag and a user-mode flag. The block reads one 32-bit descriptor from memory through a valid/ready read port and waits for the returned word. It answers with either the physical address or a fault and the fault's cause.

The directory holds 4096 four-byte descriptors, 16 KB in all. A programmable base register locates it, so rewriting the base switches the whole address map. The access decision has two layers. Every descriptor names one of 16 domains, and a domain control word gives each domain a 2-bit setting. That setting can refuse every access, admit every access while skipping the descriptor's permission bits, or pass the decision on to those permission bits, which grant separate rights to user and supervisor modes. One request is in flight at a time.

The base register and the domain control word are sampled when a request is accepted. Software can reprogram them while a walk is in progress without disturbing that walk.

Top module: `sect_xlate`

## Requirements
- R1: The descriptor fetch address is dir_base bits [31:14], followed by virtual address bits [31:20], followed by two zero bits. dir_base bits [13:0] have no effect.
- R2: req_ready is high only when no walk is active or while a response is being presented. mem_rd_valid holds high with a stable address until mem_rd_ready is seen. No new request is accepted while a fetch is outstanding.
- R3: A descriptor is a section only when bits [1:0] equal 2'b10. Any other value gives a translation fault: rsp_cause 2'b01, rsp_domain 0.
- R4: A permitted access returns rsp_fault 0, rsp_cause 2'b00 and rsp_paddr equal to descriptor bits [31:20] followed by virtual address bits [19:0].
- R5: The domain is descriptor bits [8:5]. Its setting is dom_ctrl[2d+1:2d]. A setting of 2'b00, or the reserved 2'b10, gives a domain fault: rsp_cause 2'b10.
- R6: A domain setting of 2'b11 admits the access whatever the descriptor's permission field (bits [11:10]) says.
- R7: A domain setting of 2'b01 checks the permission field. 00 denies every mode. 01 allows supervisor read/write and denies user. 10 allows supervisor read/write and user read only. 11 allows read/write in all modes. A denial gives a permission fault: rsp_cause 2'b11.
- R8: rsp_valid is a single-cycle pulse. It carries the request's virtual address on rsp_vaddr and the descriptor's domain on rsp_domain. rsp_fault is high exactly when rsp_cause is non-zero, and rsp_paddr is zero on a fault.
- R9: Changes to dir_base or dom_ctrl after a request has been accepted do not affect that request's fetch address or its verdict.
- R10: The response arrives on the cycle after the descriptor word is returned. A new request can be accepted in that same response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 32 | Physical base of the descriptor directory |
| dom_ctrl | input | 32 | 2-bit setting for each of 16 domains |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 00 none, 01 translation, 10 domain, 11 permission |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_vaddr | output | 32 | Virtual address of the answered request |
| rsp_domain | output | 4 | Domain of the descriptor, zero on translation fault |

## Verification
Two things can happen in the same cycle: presenting one response and accepting the next request. In that cycle the held address and the snapshot of the base and domain word change hands. The bench provokes this by raising the next request in the very cycle each response appears, with occasional idle gaps between. It checks that req_ready is high there and that the pending response still reports the earlier address. It also checks that the following fetch address and verdict come from the new request's snapshot. Immediately after each acceptance, the bench scrambles the base and domain inputs, so any late sampling would show up as a wrong address or a wrong cause.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

    // Address geometry
    parameter int VA_W    = 32;
    parameter int IDX_W   = 12;
    parameter int ENT_B   = 4;
    // Domain geometry
    parameter int DOM_N   = 16;
    parameter int DSET_W  = 2;
    parameter int AP_W    = 2;

    localparam int OFF_W   = VA_W - IDX_W;
    localparam int ENT_SH  = $clog2(ENT_B);
    localparam int TBL_LSB = IDX_W + ENT_SH;
    localparam int TAG_W   = VA_W - TBL_LSB;
    localparam int DOM_W   = $clog2(DOM_N);
    localparam int DCR_W   = DOM_N * DSET_W;

    // Descriptor field positions (decoded by this block)
    localparam int KIND_LSB = 0;
    localparam int DOM_LSB  = 5;
    localparam int AP_LSB   = 10;
    localparam logic [1:0] KIND_SECTION = 2'b10;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_XLAT = 2'b01,
        CAUSE_DOM  = 2'b10,
        CAUSE_PERM = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        DSET_DENY   = 2'b00,
        DSET_CLIENT = 2'b01,
        DSET_RSVD   = 2'b10,
        DSET_MGR    = 2'b11
    } dset_e;

    typedef enum logic [1:0] {
        AP_NONE      = 2'b00,
        AP_SUP       = 2'b01,
        AP_SUP_UREAD = 2'b10,
        AP_ALL       = 2'b11
    } ap_e;

    typedef struct packed {
        logic              is_sect;
        logic [IDX_W-1:0]  sect_base;
        logic [DOM_W-1:0]  dom;
        ap_e               ap;
    } sect_t;

    typedef struct packed {
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              usr;
        logic [TAG_W-1:0]  tag;
        logic [DCR_W-1:0]  dcr;
    } xreq_t;

    typedef struct packed {
        logic              fault;
        cause_e            cause;
        logic [VA_W-1:0]   pa;
        logic [DOM_W-1:0]  dom;
    } verdict_t;

    function automatic logic [VA_W-1:0] fetch_addr(
        input logic [TAG_W-1:0] tag,
        input logic [VA_W-1:0]  va
    );
        return {tag, va[VA_W-1:OFF_W], {ENT_SH{1'b0}}};
    endfunction

    function automatic logic ap_allows(input ap_e ap, input logic usr, input logic wr);
        logic ok;
        case (ap)
            AP_NONE:      ok = 1'b0;
            AP_SUP:       ok = !usr;
            AP_SUP_UREAD: ok = !usr || !wr;
            default:      ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/sxl_decode.sv
module sxl_decode
    import sxl_pkg::*;
(
    input  logic [VA_W-1:0] raw,
    output sect_t           ent
);
    always_comb begin
        ent.is_sect   = (raw[KIND_LSB +: 2] == KIND_SECTION);
        ent.sect_base = raw[VA_W-1:OFF_W];
        ent.dom       = raw[DOM_LSB +: DOM_W];
        ent.ap        = ap_e'(raw[AP_LSB +: AP_W]);
    end
endmodule

// File: rtl/sxl_policy.sv
module sxl_policy
    import sxl_pkg::*;
(
    input  sect_t             ent,
    input  logic [OFF_W-1:0]  off,
    input  logic              wr,
    input  logic              usr,
    input  logic [DCR_W-1:0]  dcr,
    output verdict_t          vd
);
    dset_e dset;

    always_comb begin
        dset     = dset_e'(dcr[int'(ent.dom)*DSET_W +: DSET_W]);
        vd       = '0;
        vd.cause = CAUSE_NONE;
        vd.dom   = ent.dom;
        if (!ent.is_sect) begin
            vd.fault = 1'b1;
            vd.cause = CAUSE_XLAT;
            vd.dom   = '0;
        end else begin
            case (dset)
                DSET_MGR: ;
                DSET_CLIENT: begin
                    if (!ap_allows(ent.ap, usr, wr)) begin
                        vd.fault = 1'b1;
                        vd.cause = CAUSE_PERM;
                    end
                end
                default: begin
                    vd.fault = 1'b1;
                    vd.cause = CAUSE_DOM;
                end
            endcase
        end
        if (!vd.fault)
            vd.pa = {ent.sect_base, off};
    end
endmodule

// File: rtl/sxl_walker.sv
module sxl_walker
    import sxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [VA_W-1:0]   dir_base,
    input  logic [DCR_W-1:0]  dom_ctrl,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    output xreq_t             cur,
    output logic              ent_take,
    output logic              rsp_live
);
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} st_e;
    st_e  st, st_n;
    logic accept;

    assign req_ready = (st == S_IDLE) || (st == S_DONE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_n = st;
        case (st)
            S_IDLE:  if (accept) st_n = S_FETCH;
            S_FETCH: if (mem_rd_ready) st_n = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) st_n = S_DONE;
            default: st_n = accept ? S_FETCH : S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            cur <= '0;
        end else begin
            st <= st_n;
            if (accept) begin
                cur.va  <= req_vaddr;
                cur.wr  <= req_write;
                cur.usr <= req_user;
                cur.tag <= dir_base[VA_W-1:TBL_LSB];
                cur.dcr <= dom_ctrl;
            end
        end
    end

    assign mem_rd_valid = (st == S_FETCH);
    assign mem_rd_addr  = fetch_addr(cur.tag, cur.va);
    assign ent_take     = (st == S_WAIT) && mem_rsp_valid;
    assign rsp_live     = (st == S_DONE);
endmodule

// File: rtl/sect_xlate.sv
module sect_xlate
    import sxl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [31:0]       dir_base,
    input  logic [31:0]       dom_ctrl,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [31:0]       rsp_paddr,
    output logic [31:0]       rsp_vaddr,
    output logic [3:0]        rsp_domain
);
    xreq_t    cur;
    logic     ent_take;
    logic     rsp_live;
    sect_t    ent;
    verdict_t vd, vd_q;

    sxl_walker u_walk (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_write    (req_write),
        .req_user     (req_user),
        .dir_base     (dir_base),
        .dom_ctrl     (dom_ctrl),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .cur          (cur),
        .ent_take     (ent_take),
        .rsp_live     (rsp_live)
    );

    sxl_decode u_dec (
        .raw (mem_rsp_data),
        .ent (ent)
    );

    sxl_policy u_pol (
        .ent (ent),
        .off (cur.va[OFF_W-1:0]),
        .wr  (cur.wr),
        .usr (cur.usr),
        .dcr (cur.dcr),
        .vd  (vd)
    );

    always_ff @(posedge clk) begin
        if (rst)
            vd_q <= '0;
        else if (ent_take)
            vd_q <= vd;
    end

    assign rsp_valid  = rsp_live;
    assign rsp_fault  = vd_q.fault;
    assign rsp_cause  = vd_q.cause;
    assign rsp_paddr  = vd_q.pa;
    assign rsp_vaddr  = cur.va;
    assign rsp_domain = vd_q.dom;
endmodule

// File: rtl/sxl_checker.sv
module sxl_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [31:0] dir_base,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [1:0]  rsp_cause,
    input logic [31:0] rsp_paddr,
    input logic [31:0] rsp_vaddr,
    input logic [3:0]  rsp_domain
);
    logic [31:0] acc_va;
    logic [17:0] acc_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_va  <= '0;
            acc_tag <= '0;
        end else if (req_valid && req_ready) begin
            acc_va  <= req_vaddr;
            acc_tag <= dir_base[31:14];
        end
    end

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> mem_rd_addr == {acc_tag, acc_va[31:20], 2'b00}); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !req_ready); // R2
    AST_XLAT_NO_DOMAIN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_cause == 2'b01 |-> rsp_domain == 4'd0); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_paddr[19:0] == acc_va[19:0]); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R8
    AST_RSP_VADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_vaddr == acc_va); // R8
    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_fault == (rsp_cause != 2'b00)); // R8
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_paddr == 32'd0); // R8
    AST_RSP_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready); // R10
endmodule

bind sect_xlate sxl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .dir_base    (dir_base),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr (mem_rd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_cause   (rsp_cause),
    .rsp_paddr   (rsp_paddr),
    .rsp_vaddr   (rsp_vaddr),
    .rsp_domain  (rsp_domain)
);

// File: tb/sim_sect_xlate.sv
`timescale 1ns/1ps
module sim_sect_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr, dir_base, dom_ctrl;
    logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
    logic [31:0] mem_rd_addr, mem_rsp_data;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr, rsp_vaddr;
    logic [3:0]  rsp_domain;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  ended  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    sect_xlate u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_entry(input logic [11:0] vi, input logic [17:0] tag);
        logic [1:0]  kind;
        logic [3:0]  dm;
        logic [11:0] sb;
        if (vi[1:0] != 2'b11) kind = 2'b10;
        else case (vi[5:4])
            2'd0: kind = 2'b00;
            2'd1: kind = 2'b01;
            2'd2: kind = 2'b11;
            default: kind = 2'b00;
        endcase
        dm = vi[7:4] ^ vi[11:8];
        sb = vi ^ tag[11:0] ^ 12'hA5C;
        return {sb, 8'h5A, vi[3:2], 1'b1, dm, 3'b101, kind};
    endfunction

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic issue(input logic [31:0] va, input bit w, input bit u,
                         input logic [31:0] b, input logic [31:0] dc, input bit overlap);
        if (overlap)
            chk(req_ready === 1'b1, "R10 ready during response", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
        dir_base = b; dom_ctrl = dc;
        while (req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = ~va;
        dir_base  = ~b;
        dom_ctrl  = ~dc;
    endtask

    task automatic serve(input logic [31:0] va, input bit w, input bit u,
                         input logic [31:0] b, input logic [31:0] dc,
                         input int stall, input int delay);
        logic [31:0] ex_addr, ent, ex_pa;
        logic [1:0]  ex_cause, s;
        logic [3:0]  ex_dom;
        logic [1:0]  ap;
        bit          ok;
        string       tag;
        ex_addr = {b[31:14], va[31:20], 2'b00};
        for (int k = 0; k < stall; k++) begin
            mem_rd_ready = 1'b0;
            if (mem_rd_valid !== 1'b1 || mem_rd_addr !== ex_addr)
                chk(1'b0, "R2 read held", {31'd0, mem_rd_valid, mem_rd_addr}, {31'd1, ex_addr});
            @(negedge clk);
        end
        mem_rd_ready = 1'b1;
        chk(mem_rd_valid === 1'b1 && mem_rd_addr === ex_addr, "R1 R9 fetch address",
            {31'd0, mem_rd_valid, mem_rd_addr}, {31'd1, ex_addr});
        ent = mk_entry(mem_rd_addr[13:2], mem_rd_addr[31:14]);
        @(negedge clk);
        mem_rd_ready = 1'b0;
        for (int k = 0; k < delay; k++) begin
            if (mem_rd_valid !== 1'b0 || req_ready !== 1'b0)
                chk(1'b0, "R2 single outstanding", {62'd0, mem_rd_valid, req_ready}, 64'd0);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = ent;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
        // expected verdict from the intended descriptor
        ent    = mk_entry(va[31:20], b[31:14]);
        ex_dom = ent[8:5];
        ap     = ent[11:10];
        s      = dc[2*ent[8:5] +: 2];
        ex_cause = 2'b00;
        if (ent[1:0] != 2'b10) begin
            ex_cause = 2'b01; ex_dom = 4'd0; tag = "R3 translation fault";
        end else if (s == 2'b00 || s == 2'b10) begin
            ex_cause = 2'b10; tag = "R5 domain fault";
        end else if (s == 2'b11) begin
            tag = "R6 R4 manager pass";
        end else begin
            ok = u ? (ap == 2'b11 || (ap == 2'b10 && !w)) : (ap != 2'b00);
            if (!ok) ex_cause = 2'b11;
            tag = ok ? "R7 R4 client allow" : "R7 permission fault";
        end
        ex_pa = (ex_cause == 2'b00) ? {ent[31:20], va[19:0]} : 32'd0;
        chk(rsp_valid === 1'b1 && rsp_fault === (ex_cause != 2'b00) && rsp_cause === ex_cause
            && rsp_domain === ex_dom && rsp_paddr === ex_pa && rsp_vaddr === va,
            {tag, " R8 R9 R10"},
            {rsp_valid, rsp_fault, rsp_cause, rsp_domain, 24'd0, rsp_paddr},
            {1'b1, ex_cause != 2'b00, ex_cause, ex_dom, 24'd0, ex_pa});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h5555_5555;
        pats[3] = 32'hAAAA_AAAA; pats[4] = 32'hE4E4_E4E4; pats[5] = 32'h1B1B_1B1B;
        rst = 1'b1; req_valid = 0; req_vaddr = 0; req_write = 0; req_user = 0;
        dir_base = 0; dom_ctrl = 0; mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(req_ready === 1'b1 && mem_rd_valid === 1'b0 && rsp_valid === 1'b0, "R2 R8 reset state",
            {61'd0, req_ready, mem_rd_valid, rsp_valid}, 64'd4);
        begin
            bit first = 1'b1;
            for (int p = 0; p < 6; p++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int i = 0; i < 256; i++) begin
                        logic [31:0] va, b;
                        bit ov;
                        lfsr = step(lfsr);
                        va = {p[1:0], m[1:0], i[7:0], lfsr, lfsr[3:0]};
                        b  = {p[3:0] ^ 4'h9, i[7:0] ^ 8'h3C, m[1:0], lfsr[3:0], lfsr[13:0]};
                        ov = !first && !lfsr[4];
                        if (!first && lfsr[4]) @(negedge clk);
                        issue(va, m[0], m[1], b, pats[p], ov);
                        serve(va, m[0], m[1], b, pats[p], lfsr[6:5] % 3, lfsr[8:7] % 3);
                        first = 1'b0;
                    end
                end
            end
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 pulse ends",
            {62'd0, rsp_valid, req_ready}, 64'd1);
        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule